// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block runs exactly once after each reset and walks an attached SDRAM from power-up to a usable state. It holds the clock-enable pin high and every byte-mask bit high, and drives no-operation on the command pins. It keeps this up for a programmable settling interval counted in clock cycles. It then closes all banks with a precharge and issues a programmable number of auto-refresh commands. It also issues a load-mode command that carries the configuration word.

Between steps it waits fixed recovery intervals: row-precharge time after the precharge, row-cycle time after each refresh, and mode-set recovery after the load-mode command. A parameter chooses whether the refreshes come before or after the load-mode command. When the last recovery interval has elapsed, the sequencer raises `init_done` and leaves it high until the next reset. A normal-operation controller can then take over the pins.

Every output is a register. Commands are one-cycle pulses with no-operation cycles between them. After reset is released, clock edges are counted from 1, and every cycle index below uses that count.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, the outputs are: clock-enable 1, byte mask all ones, command no-operation (select/row/column/write = 0/1/1/1), init_done 0.
- R2: The command pins show no-operation on edges 1 to WAIT_CYCLES-1. The precharge command (0/0/1/0) appears on edge WAIT_CYCLES exactly.
- R3: The precharge command drives address bit 10 high, so that all banks are selected.
- R4: The next command after the precharge comes exactly T_RP cycles after it.
- R5: REFRESH_COUNT auto-refresh commands (0/0/0/1) are issued. Each refresh is followed by exactly T_RC cycles before the next command, or before init_done rises.
- R6: The load-mode command (0/0/0/0) drives bank = 0 and this address word: bits [2:0] burst-length code, bit 3 burst type, bits [6:4] CAS latency, bit 9 single-location write, bits 10, 8 and 7 zero.
- R7: With MODE_FIRST = 0 the refreshes come before the load-mode command. With MODE_FIRST = 1 the load-mode command comes first and the refreshes follow it.
- R8: The next command after the load-mode command, or the rise of init_done, comes exactly T_MRD cycles after it.
- R9: init_done stays high until reset, and only no-operation is driven while it is high.
- R10: Every command lasts one cycle and is followed by at least one no-operation cycle.
- R11: Clock-enable stays 1 and the byte mask stays all ones throughout the sequence and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mem_clk_en | output | 1 | Memory clock-enable pin |
| mem_byte_mask | output | MASK_W | Memory byte-mask pins |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_row_n | output | 1 | Row strobe, active low |
| mem_col_n | output | 1 | Column strobe, active low |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_bank | output | BANK_W | Bank select pins |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The bench looks for off-by-one errors in each recovery counter. A timer loaded one short or one long would move the precharge, a refresh or the load-mode command by a cycle. The per-cycle comparison against the expected event table catches that shift. Two instances with different counts and orderings check that the order parameter really swaps the steps and that the refresh count is honoured. Because the field values are asymmetric, a wrong bit position in the mode word shows up as a wrong address. Resetting in the middle of a refresh gap checks that the wait counter and the refresh count reload, and that the precharge lands on the same edge again rather than resuming the old sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_PRE_GAP,
    ST_REF,
    ST_REF_GAP,
    ST_MRS,
    ST_MRS_GAP,
    ST_DONE
  } init_state_t;

  // {select_n, row_n, col_n, write_n}
  typedef enum logic [3:0] {
    CMD_NOP       = 4'b0111,
    CMD_PRECHARGE = 4'b0010,
    CMD_REFRESH   = 4'b0001,
    CMD_LOAD_MODE = 4'b0000
  } mem_cmd_t;

  function automatic logic [10:0] mode_word(input logic [2:0] cas_lat,
                                            input logic       burst_ilv,
                                            input logic [2:0] burst_code,
                                            input logic       single_wr);
    logic [10:0] w;
    w        = '0;
    w[2:0]   = burst_code;
    w[3]     = burst_ilv;
    w[6:4]   = cas_lat;
    w[9]     = single_wr;
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W     = 16,
  parameter int RESET_VAL = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(RESET_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int REFRESH_COUNT = 2,
  parameter int T_RP          = 3,
  parameter int T_RC          = 10,
  parameter int T_MRD         = 2,
  parameter bit MODE_FIRST    = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_value,
  output mem_cmd_t         cmd_next,
  output logic             done_next
);
  localparam int RC_W = $clog2(REFRESH_COUNT + 1);

  init_state_t     state, state_d;
  logic [RC_W-1:0] ref_left;

  always_comb begin
    state_d   = state;
    tmr_load  = 1'b0;
    tmr_value = '0;
    if (tmr_zero) begin
      unique case (state)
        ST_WAIT: begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
        end
        ST_PRE: begin
          state_d   = ST_PRE_GAP;
          tmr_load  = 1'b1;
          tmr_value = CNT_W'(T_RP - 2);
        end
        ST_PRE_GAP: begin
          state_d  = MODE_FIRST ? ST_MRS : ST_REF;
          tmr_load = 1'b1;
        end
        ST_REF: begin
          state_d   = ST_REF_GAP;
          tmr_load  = 1'b1;
          tmr_value = CNT_W'(T_RC - 2);
        end
        ST_REF_GAP: begin
          tmr_load = 1'b1;
          if (ref_left != '0)  state_d = ST_REF;
          else if (MODE_FIRST) state_d = ST_DONE;
          else                 state_d = ST_MRS;
        end
        ST_MRS: begin
          state_d   = ST_MRS_GAP;
          tmr_load  = 1'b1;
          tmr_value = CNT_W'(T_MRD - 2);
        end
        ST_MRS_GAP: begin
          state_d  = MODE_FIRST ? ST_REF : ST_DONE;
          tmr_load = 1'b1;
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_WAIT;
      ref_left <= RC_W'(REFRESH_COUNT);
    end else begin
      state <= state_d;
      if (state == ST_REF && tmr_zero) ref_left <= ref_left - RC_W'(1);
    end
  end

  always_comb begin
    unique case (state_d)
      ST_PRE:  cmd_next = CMD_PRECHARGE;
      ST_REF:  cmd_next = CMD_REFRESH;
      ST_MRS:  cmd_next = CMD_LOAD_MODE;
      default: cmd_next = CMD_NOP;
    endcase
  end

  assign done_next = (state_d == ST_DONE);
endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter int          BANK_W = 2,
  parameter int          MASK_W = 4,
  parameter logic [10:0] MODE   = 11'h033
) (
  input  logic              clk,
  input  logic              rst,
  input  mem_cmd_t          cmd_next,
  input  logic              done_next,
  output logic              clk_en,
  output logic [MASK_W-1:0] byte_mask,
  output logic [3:0]        cmd_pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              done
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(11'h400);
  localparam logic [ADDR_W-1:0] MODE_EXT  = ADDR_W'(MODE);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (cmd_next)
      CMD_PRECHARGE: addr_d = ALL_BANKS;
      CMD_LOAD_MODE: addr_d = MODE_EXT;
      default:       addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en    <= 1'b1;
      byte_mask <= '1;
      cmd_pins  <= CMD_NOP;
      addr      <= '0;
      bank      <= '0;
      done      <= 1'b0;
    end else begin
      clk_en    <= 1'b1;
      byte_mask <= '1;
      cmd_pins  <= cmd_next;
      addr      <= addr_d;
      bank      <= '0;
      done      <= done_next;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int         WAIT_CYCLES    = 10000,
  parameter int         REFRESH_COUNT  = 2,
  parameter int         T_RP           = 3,
  parameter int         T_RC           = 10,
  parameter int         T_MRD          = 2,
  parameter bit         MODE_FIRST     = 1'b0,
  parameter logic [2:0] CAS_LATENCY    = 3'd3,
  parameter bit         BURST_ILV      = 1'b0,
  parameter logic [2:0] BURST_LEN_CODE = 3'b011,
  parameter bit         SINGLE_WRITE   = 1'b0,
  parameter int         ADDR_W         = 11,
  parameter int         BANK_W         = 2,
  parameter int         MASK_W         = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_clk_en,
  output logic [MASK_W-1:0] mem_byte_mask,
  output logic              mem_sel_n,
  output logic              mem_row_n,
  output logic              mem_col_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_bank,
  output logic              init_done
);
  localparam int MAX_A   = (WAIT_CYCLES > T_RC) ? WAIT_CYCLES : T_RC;
  localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [10:0] MODE_WORD =
    mode_word(CAS_LATENCY, BURST_ILV, BURST_LEN_CODE, SINGLE_WRITE);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_value;
  mem_cmd_t         cmd_next;
  logic             done_next;
  logic [3:0]       cmd_pins;

  sdram_init_timer #(
    .CNT_W    (CNT_W),
    .RESET_VAL(WAIT_CYCLES - 1)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_value),
    .zero    (tmr_zero)
  );

  sdram_init_fsm #(
    .CNT_W        (CNT_W),
    .REFRESH_COUNT(REFRESH_COUNT),
    .T_RP         (T_RP),
    .T_RC         (T_RC),
    .T_MRD        (T_MRD),
    .MODE_FIRST   (MODE_FIRST)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_value(tmr_value),
    .cmd_next (cmd_next),
    .done_next(done_next)
  );

  sdram_init_pins #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .MASK_W(MASK_W),
    .MODE  (MODE_WORD)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .cmd_next (cmd_next),
    .done_next(done_next),
    .clk_en   (mem_clk_en),
    .byte_mask(mem_byte_mask),
    .cmd_pins (cmd_pins),
    .addr     (mem_addr),
    .bank     (mem_bank),
    .done     (init_done)
  );

  assign {mem_sel_n, mem_row_n, mem_col_n, mem_wr_n} = cmd_pins;
endmodule

// File: rtl/sdram_init_seq_checker.sv
module sdram_init_seq_checker #(
  parameter int          T_RP      = 3,
  parameter int          T_RC      = 10,
  parameter int          T_MRD     = 2,
  parameter int          ADDR_W    = 11,
  parameter int          BANK_W    = 2,
  parameter logic [10:0] MODE_WORD = 11'h033
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_sel_n,
  input logic              mem_row_n,
  input logic              mem_col_n,
  input logic              mem_wr_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BANK_W-1:0] mem_bank,
  input logic              init_done
);
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] MRS = 4'b0000;

  logic [3:0]  cmd, last_cmd;
  logic [15:0] gap;

  assign cmd = {mem_sel_n, mem_row_n, mem_col_n, mem_wr_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd <= NOP;
      gap      <= '0;
    end else if (cmd != NOP) begin
      last_cmd <= cmd;
      gap      <= 16'd1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == PRE) |-> mem_addr[10]);

  p_mode_word_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == MRS) |-> (mem_addr == ADDR_W'(MODE_WORD) && mem_bank == '0));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd != NOP) |=> (cmd == NOP));

  p_precharge_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd != NOP && last_cmd == PRE) |-> (gap == 16'(T_RP)));

  p_refresh_gap_r5: assert property (@(posedge clk) disable iff (rst)
    ((cmd != NOP || $rose(init_done)) && last_cmd == REF) |-> (gap == 16'(T_RC)));

  p_mode_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ((cmd != NOP || $rose(init_done)) && last_cmd == MRS) |-> (gap == 16'(T_MRD)));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == NOP));
endmodule

bind sdram_init_seq sdram_init_seq_checker #(
  .T_RP     (T_RP),
  .T_RC     (T_RC),
  .T_MRD    (T_MRD),
  .ADDR_W   (ADDR_W),
  .BANK_W   (BANK_W),
  .MODE_WORD(MODE_WORD)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .mem_sel_n(mem_sel_n),
  .mem_row_n(mem_row_n),
  .mem_col_n(mem_col_n),
  .mem_wr_n (mem_wr_n),
  .mem_addr (mem_addr),
  .mem_bank (mem_bank),
  .init_done(init_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  // instance A: refreshes first
  localparam int A_W = 20, A_N = 2, A_RP = 3, A_RC = 10, A_MRD = 2;
  // instance B: load-mode first
  localparam int B_W = 15, B_N = 3, B_RP = 4, B_RC = 6, B_MRD = 3;

  // R6 field layout: [2:0] burst code, [3] burst type, [6:4] latency, [9] single write
  localparam logic [10:0] A_WORD = 11'((3 << 4) | 3);
  localparam logic [10:0] B_WORD = 11'((1 << 9) | (2 << 4) | (1 << 3) | 2);

  localparam int A_DONE = A_W + A_RP + A_N * A_RC + A_MRD;
  localparam int B_DONE = B_W + B_RP + B_MRD + B_N * B_RC;

  localparam int A_NEV = 4;
  localparam int A_EV_CYC [A_NEV] = '{A_W, A_W + A_RP, A_W + A_RP + A_RC,
                                      A_W + A_RP + 2 * A_RC};
  localparam logic [3:0] A_EV_CMD [A_NEV] = '{C_PRE, C_REF, C_REF, C_MRS};

  localparam int B_NEV = 5;
  localparam int B_EV_CYC [B_NEV] = '{B_W, B_W + B_RP, B_W + B_RP + B_MRD,
                                      B_W + B_RP + B_MRD + B_RC,
                                      B_W + B_RP + B_MRD + 2 * B_RC};
  localparam logic [3:0] B_EV_CMD [B_NEV] = '{C_PRE, C_MRS, C_REF, C_REF, C_REF};

  logic clk = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  always #10 clk = ~clk;

  logic        cke_a, cke_b, done_a, done_b;
  logic [3:0]  dqm_a, dqm_b;
  logic        s_a, r_a, c_a, w_a, s_b, r_b, c_b, w_b;
  logic [10:0] addr_a, addr_b;
  logic [1:0]  ba_a, ba_b;

  sdram_init_seq #(
    .WAIT_CYCLES(A_W), .REFRESH_COUNT(A_N), .T_RP(A_RP), .T_RC(A_RC),
    .T_MRD(A_MRD), .MODE_FIRST(1'b0), .CAS_LATENCY(3'd3), .BURST_ILV(1'b0),
    .BURST_LEN_CODE(3'b011), .SINGLE_WRITE(1'b0)
  ) u_sdram_init_seq (
    .clk(clk), .rst(rst_a), .mem_clk_en(cke_a), .mem_byte_mask(dqm_a),
    .mem_sel_n(s_a), .mem_row_n(r_a), .mem_col_n(c_a), .mem_wr_n(w_a),
    .mem_addr(addr_a), .mem_bank(ba_a), .init_done(done_a)
  );

  sdram_init_seq #(
    .WAIT_CYCLES(B_W), .REFRESH_COUNT(B_N), .T_RP(B_RP), .T_RC(B_RC),
    .T_MRD(B_MRD), .MODE_FIRST(1'b1), .CAS_LATENCY(3'd2), .BURST_ILV(1'b1),
    .BURST_LEN_CODE(3'b010), .SINGLE_WRITE(1'b1)
  ) u_sdram_init_seq_b (
    .clk(clk), .rst(rst_b), .mem_clk_en(cke_b), .mem_byte_mask(dqm_b),
    .mem_sel_n(s_b), .mem_row_n(r_b), .mem_col_n(c_b), .mem_wr_n(w_b),
    .mem_addr(addr_b), .mem_bank(ba_b), .init_done(done_b)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_a(input int k);
    logic [3:0] c = C_NOP;
    for (int i = 0; i < A_NEV; i++) if (A_EV_CYC[i] == k) c = A_EV_CMD[i];
    return c;
  endfunction

  function automatic logic [3:0] exp_b(input int k);
    logic [3:0] c = C_NOP;
    for (int i = 0; i < B_NEV; i++) if (B_EV_CYC[i] == k) c = B_EV_CMD[i];
    return c;
  endfunction

  task automatic check_pins(input string tag, input int k, input logic [3:0] cmd,
                            input logic [3:0] ecmd, input logic [10:0] addr,
                            input logic [10:0] eword, input logic [1:0] ba,
                            input logic cke, input logic [3:0] dqm,
                            input logic done, input int dcyc);
    check(cmd == ecmd, "R2,R4,R5,R7,R10", $sformatf("%s cmd @%0d", tag, k), cmd, ecmd);
    if (ecmd == C_PRE)
      check(addr[10] == 1'b1, "R3", $sformatf("%s A10 @%0d", tag, k), addr, 11'h400);
    if (ecmd == C_MRS)
      check(addr == eword && ba == 2'b00, "R6", $sformatf("%s mode @%0d", tag, k),
            {ba, addr}, {2'b00, eword});
    check(cke && dqm == 4'hF, "R11", $sformatf("%s cke/mask @%0d", tag, k),
          {cke, dqm}, 5'h1F);
    check(done == (k >= dcyc), "R8,R9", $sformatf("%s done @%0d", tag, k),
          done, (k >= dcyc));
  endtask

  task automatic check_reset(input string tag, input logic [3:0] cmd, input logic cke,
                             input logic [3:0] dqm, input logic done);
    check(cmd == C_NOP && cke && dqm == 4'hF && !done, "R1",
          $sformatf("%s reset state", tag), {cmd, cke, dqm, done}, {C_NOP, 1'b1, 4'hF, 1'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("A", {s_a, r_a, c_a, w_a}, cke_a, dqm_a, done_a);
    check_reset("B", {s_b, r_b, c_b, w_b}, cke_b, dqm_b, done_b);
    rst_a = 1'b0;
    rst_b = 1'b0;

    // main walk over both instances against the event tables
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_pins("A", k, {s_a, r_a, c_a, w_a}, exp_a(k), addr_a, A_WORD, ba_a,
                 cke_a, dqm_a, done_a, A_DONE);
      check_pins("B", k, {s_b, r_b, c_b, w_b}, exp_b(k), addr_b, B_WORD, ba_b,
                 cke_b, dqm_b, done_b, B_DONE);
    end

    // R9: done held long after completion, cleared only by reset
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(done_a && done_b, "R9", "done still held", {done_a, done_b}, 2'b11);
    rst_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset("A after done", {s_a, r_a, c_a, w_a}, cke_a, dqm_a, done_a);
    rst_a = 1'b0;

    // partial run, then reset inside the first refresh gap
    for (int k = 1; k <= A_W + A_RP + 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_pins("A run2", k, {s_a, r_a, c_a, w_a}, exp_a(k), addr_a, A_WORD, ba_a,
                 cke_a, dqm_a, done_a, A_DONE);
    end
    rst_a = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset("A mid-refresh", {s_a, r_a, c_a, w_a}, cke_a, dqm_a, done_a);
    rst_a = 1'b0;

    // R2: the full wait restarts, precharge lands on edge A_W again
    for (int k = 1; k <= A_W + A_RP + A_RC + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_pins("A run3", k, {s_a, r_a, c_a, w_a}, exp_a(k), addr_a, A_WORD, ba_a,
                 cke_a, dqm_a, done_a, A_DONE);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule